// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Sequencer

This block is the control sequencer that brings one instruction into a processor's instruction registers. An instruction is one to four bytes long. The length is not known up front. The sequencer fetches one byte at a time from a byte-wide memory and writes it into its own slot of the instruction register. After each byte it looks at decode flags, which an outside decoder produces from the bytes already held, and picks one of four moves: fetch another byte, go to operand handling, go straight to execute, or give up on an illegal encoding.

Each byte fetch runs in three steps. First the program counter is copied into the memory address register and incremented in the same cycle. Then the sequencer waits while the bus is busy. Then it holds a read request until memory reports completion. The second byte also loads the register-file address register. An illegal opcode or an illegal addressing mode sets a sticky error bit and jumps to the interrupt-check phase without executing. Operand fetch and execution belong to other blocks. Here they appear only as one-cycle phases, so the external phase code shows how each instruction ended.

Top module: `ifetch_seq`

## Requirements
- R1: A synchronous reset puts the sequencer in the idle phase (code 0). In the cycle after reset, all IR load enables, the MAR load, the PC increment and the read request are low, both error bits are clear and the byte count is 0.
- R2: While idle with `startReq` low, the sequencer stays idle and issues no MAR load.
- R3: For every byte, `marLoad` and `pcIncr` are high together for exactly one cycle. `memRd` rises only after a cycle in which `busBusy` was low. `memRd` stays high until `memDone`.
- R4: Byte k of the instruction (k = 0..3) is written into `instrBytes[8k+7:8k]` with the value that `memData` carried when `memDone` was seen. `irLoad[k]` pulses for it, at most one enable is high at a time, and `byteCount` reports how many bytes the current instruction has taken.
- R5: When `decIllegalOp` is high at the byte-0 decision, `errOpcode` is set and the sequencer goes to the interrupt phase after one byte, with no operand or execute phase.
- R6: When `decOneByte` is high at the byte-0 decision (and `decIllegalOp` is low), the sequencer goes to execute after one byte.
- R7: In the same cycle that byte 1 is written, `gprAdr` is loaded from the low `GPR_W` bits of that byte.
- R8: When `decIllegalMode` is high at the byte-1 decision, `errMode` is set and the sequencer goes to the interrupt phase after two bytes.
- R9: At the byte-1 decision, `decBranch` leads to execute and `decRegDirArith` leads to the operand phase, each after two bytes.
- R10: At the byte-2 decision, `decJump` leads to execute and `decArith` leads to the operand phase, each after three bytes. Otherwise a fourth byte is fetched and the operand phase follows.
- R11: `errOpcode` and `errMode` stay set through later instructions until reset.
- R12: Phase codes are idle 0, fetch 1, operand 2, execute 3, interrupt 4. Operand lasts one cycle and is followed by execute. Execute is followed by interrupt, and interrupt by idle.
- R13: At each decision the illegal flag outranks the others. `decBranch` outranks `decRegDirArith`, and `decJump` outranks `decArith`. Flags that belong to other byte positions are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | Permission to begin the next instruction fetch |
| busBusy | input | 1 | Bus not yet available; the read is held off |
| memDone | input | 1 | Memory read complete, `memData` valid |
| memData | input | BYTE_W | Byte returned by memory |
| decIllegalOp | input | 1 | Decoder: opcode is illegal |
| decOneByte | input | 1 | Decoder: instruction is one byte long |
| decIllegalMode | input | 1 | Decoder: addressing mode is illegal |
| decBranch | input | 1 | Decoder: conditional branch |
| decRegDirArith | input | 1 | Decoder: arithmetic/logic op with register-direct operand |
| decJump | input | 1 | Decoder: jump-class instruction |
| decArith | input | 1 | Decoder: arithmetic/logic op |
| marLoad | output | 1 | Copy PC to MAR |
| pcIncr | output | 1 | Increment PC |
| memRd | output | 1 | Memory read request |
| irLoad | output | MAX_BYTES | One-hot IR slot write enable |
| gprAdrLoad | output | 1 | Register-file address register load strobe |
| instrBytes | output | BYTE_W*MAX_BYTES | Instruction register contents, byte 0 lowest |
| gprAdr | output | GPR_W | Register-file address |
| errOpcode | output | 1 | Sticky illegal-opcode error |
| errMode | output | 1 | Sticky illegal-addressing error |
| phase | output | 3 | Current phase code |
| byteCount | output | $clog2(MAX_BYTES+1) | Bytes taken by the current instruction |

## Verification
The hardest cases to reach are the ones where several decode flags are high at once. There the outcome depends only on which byte position is being decided and on the priority order. The stimulus therefore holds combined flag patterns steady over a whole instruction, for example every flag except the illegal opcode together with the one-byte flag. This shows that each decision reads only the flags for its own position. Bus-busy stretches and read latencies vary between instructions, so the handshake is seen in its waiting states. A reset is also raised in the middle of a pending read, which shows that the sequencer abandons the fetch cleanly.

// File: rtl/ifetch_pkg.sv
`timescale 1ns/1ps
package ifetch_pkg;

  // Width of the byte-slot index carried from control to datapath (up to 8 slots)
  localparam int IDX_W = 3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT,
    ST_READ,
    ST_LOAD,
    ST_DECIDE,
    ST_OPER,
    ST_EXEC,
    ST_INTR
  } seqState_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_FETCH = 3'd1,
    PH_OPER  = 3'd2,
    PH_EXEC  = 3'd3,
    PH_INTR  = 3'd4
  } phase_e;

  typedef struct packed {
    logic illOp;
    logic oneByte;
    logic illMode;
    logic branch;
    logic regDirArith;
    logic jump;
    logic arith;
  } decFlags_t;

  typedef enum logic [1:0] {
    NX_FETCH,
    NX_EXEC,
    NX_OPER,
    NX_INTR
  } nextStep_e;

  typedef struct packed {
    nextStep_e step;
    logic      setErrOp;
    logic      setErrMode;
  } decision_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic             mdrLoad;
    logic             irWrite;
    logic [IDX_W-1:0] irSlot;
    logic             gprLoad;
    logic             cntClear;
    logic             setErrOp;
    logic             setErrMode;
  } dpStrobes_t;

endpackage

// File: rtl/ifetch_decide.sv
`timescale 1ns/1ps
module ifetch_decide
  import ifetch_pkg::*;
#(
  parameter int MAX_BYTES = 4
) (
  input  logic [IDX_W-1:0] byteIdx,
  input  decFlags_t        flags,
  output decision_t        dec
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MAX_BYTES - 1);
  localparam logic [IDX_W-1:0] IDX_OPC  = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_MODE = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_EXT  = IDX_W'(2);

  always_comb begin
    dec.step       = NX_FETCH;
    dec.setErrOp   = 1'b0;
    dec.setErrMode = 1'b0;

    if (byteIdx == IDX_OPC) begin
      if (flags.illOp) begin
        dec.step     = NX_INTR;
        dec.setErrOp = 1'b1;
      end else if (flags.oneByte) begin
        dec.step = NX_EXEC;
      end
    end else if (byteIdx == IDX_MODE) begin
      if (flags.illMode) begin
        dec.step       = NX_INTR;
        dec.setErrMode = 1'b1;
      end else if (flags.branch) begin
        dec.step = NX_EXEC;
      end else if (flags.regDirArith) begin
        dec.step = NX_OPER;
      end
    end else if (byteIdx == IDX_EXT) begin
      if (flags.jump) begin
        dec.step = NX_EXEC;
      end else if (flags.arith) begin
        dec.step = NX_OPER;
      end
    end

    // No slot left: the instruction is complete, hand over to operand handling
    if (byteIdx >= LAST_IDX && dec.step == NX_FETCH) begin
      dec.step = NX_OPER;
    end
  end

endmodule

// File: rtl/ifetch_ctrl.sv
`timescale 1ns/1ps
module ifetch_ctrl
  import ifetch_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             startReq,
  input  logic             busBusy,
  input  logic             memDone,
  input  decision_t        dec,
  output logic [IDX_W-1:0] byteIdx,
  output logic             marLoad,
  output logic             pcIncr,
  output logic             memRd,
  output dpStrobes_t       dpStb,
  output phase_e           phase
);

  seqState_e state, stateNxt;
  logic [IDX_W-1:0] idxNxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      byteIdx <= '0;
    end else begin
      state   <= stateNxt;
      byteIdx <= idxNxt;
    end
  end

  always_comb begin
    stateNxt = state;
    idxNxt   = byteIdx;
    unique case (state)
      ST_IDLE: begin
        idxNxt = '0;
        if (startReq) stateNxt = ST_ADDR;
      end
      ST_ADDR:  stateNxt = ST_WAIT;
      ST_WAIT:  if (!busBusy) stateNxt = ST_READ;
      ST_READ:  if (memDone) stateNxt = ST_LOAD;
      ST_LOAD:  stateNxt = ST_DECIDE;
      ST_DECIDE: begin
        unique case (dec.step)
          NX_FETCH: begin
            stateNxt = ST_ADDR;
            idxNxt   = byteIdx + IDX_W'(1);
          end
          NX_EXEC: stateNxt = ST_EXEC;
          NX_OPER: stateNxt = ST_OPER;
          NX_INTR: stateNxt = ST_INTR;
          default: stateNxt = ST_INTR;
        endcase
      end
      ST_OPER: stateNxt = ST_EXEC;
      ST_EXEC: stateNxt = ST_INTR;
      ST_INTR: begin
        stateNxt = ST_IDLE;
        idxNxt   = '0;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_comb begin
    marLoad          = 1'b0;
    pcIncr           = 1'b0;
    memRd            = 1'b0;
    dpStb            = '0;
    dpStb.irSlot     = byteIdx;
    unique case (state)
      ST_IDLE: dpStb.cntClear = 1'b1;
      ST_ADDR: begin
        marLoad = 1'b1;
        pcIncr  = 1'b1;
      end
      ST_READ: begin
        memRd         = 1'b1;
        dpStb.mdrLoad = memDone;
      end
      ST_LOAD: begin
        dpStb.irWrite = 1'b1;
        dpStb.gprLoad = (byteIdx == IDX_W'(1));
      end
      ST_DECIDE: begin
        dpStb.setErrOp   = dec.setErrOp;
        dpStb.setErrMode = dec.setErrMode;
      end
      default: ;
    endcase
  end

  always_comb begin
    unique case (state)
      ST_IDLE:                                          phase = PH_IDLE;
      ST_ADDR, ST_WAIT, ST_READ, ST_LOAD, ST_DECIDE:    phase = PH_FETCH;
      ST_OPER:                                          phase = PH_OPER;
      ST_EXEC:                                          phase = PH_EXEC;
      ST_INTR:                                          phase = PH_INTR;
      default:                                          phase = PH_IDLE;
    endcase
  end

endmodule

// File: rtl/ifetch_dpath.sv
`timescale 1ns/1ps
module ifetch_dpath
  import ifetch_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int MAX_BYTES = 4,
  parameter int GPR_W     = 3,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  dpStrobes_t                  dpStb,
  input  logic [BYTE_W-1:0]           memData,
  output logic [MAX_BYTES-1:0]        irLoad,
  output logic                        gprAdrLoad,
  output logic [BYTE_W*MAX_BYTES-1:0] instrBytes,
  output logic [GPR_W-1:0]            gprAdr,
  output logic                        errOpcode,
  output logic                        errMode,
  output logic [CNT_W-1:0]            byteCount
);

  logic [BYTE_W-1:0] mdr;

  always_ff @(posedge clk) begin
    if (rst) mdr <= '0;
    else if (dpStb.mdrLoad) mdr <= memData;
  end

  // One register per instruction byte, each with its own decoded enable
  for (genvar s = 0; s < MAX_BYTES; s++) begin : g_slot
    logic [BYTE_W-1:0] irReg;
    assign irLoad[s] = dpStb.irWrite && (dpStb.irSlot == IDX_W'(s));
    always_ff @(posedge clk) begin
      if (rst) irReg <= '0;
      else if (irLoad[s]) irReg <= mdr;
    end
    assign instrBytes[s*BYTE_W +: BYTE_W] = irReg;
  end

  assign gprAdrLoad = dpStb.gprLoad;

  always_ff @(posedge clk) begin
    if (rst) gprAdr <= '0;
    else if (gprAdrLoad) gprAdr <= mdr[GPR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      errOpcode <= 1'b0;
      errMode   <= 1'b0;
    end else begin
      if (dpStb.setErrOp)   errOpcode <= 1'b1;
      if (dpStb.setErrMode) errMode   <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || dpStb.cntClear) byteCount <= '0;
    else if (dpStb.irWrite) byteCount <= byteCount + CNT_W'(1);
  end

endmodule

// File: rtl/ifetch_seq.sv
`timescale 1ns/1ps
module ifetch_seq
  import ifetch_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int MAX_BYTES = 4,
  parameter int GPR_W     = 3,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        startReq,
  input  logic                        busBusy,
  input  logic                        memDone,
  input  logic [BYTE_W-1:0]           memData,
  input  logic                        decIllegalOp,
  input  logic                        decOneByte,
  input  logic                        decIllegalMode,
  input  logic                        decBranch,
  input  logic                        decRegDirArith,
  input  logic                        decJump,
  input  logic                        decArith,
  output logic                        marLoad,
  output logic                        pcIncr,
  output logic                        memRd,
  output logic [MAX_BYTES-1:0]        irLoad,
  output logic                        gprAdrLoad,
  output logic [BYTE_W*MAX_BYTES-1:0] instrBytes,
  output logic [GPR_W-1:0]            gprAdr,
  output logic                        errOpcode,
  output logic                        errMode,
  output logic [2:0]                  phase,
  output logic [CNT_W-1:0]            byteCount
);

  decFlags_t        flags;
  decision_t        dec;
  dpStrobes_t       dpStb;
  logic [IDX_W-1:0] byteIdx;
  phase_e           phaseEnum;

  assign flags = '{illOp:       decIllegalOp,
                   oneByte:     decOneByte,
                   illMode:     decIllegalMode,
                   branch:      decBranch,
                   regDirArith: decRegDirArith,
                   jump:        decJump,
                   arith:       decArith};

  ifetch_decide #(.MAX_BYTES(MAX_BYTES)) decide_i (
    .byteIdx (byteIdx),
    .flags   (flags),
    .dec     (dec)
  );

  ifetch_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .startReq (startReq),
    .busBusy  (busBusy),
    .memDone  (memDone),
    .dec      (dec),
    .byteIdx  (byteIdx),
    .marLoad  (marLoad),
    .pcIncr   (pcIncr),
    .memRd    (memRd),
    .dpStb    (dpStb),
    .phase    (phaseEnum)
  );

  ifetch_dpath #(
    .BYTE_W    (BYTE_W),
    .MAX_BYTES (MAX_BYTES),
    .GPR_W     (GPR_W)
  ) dpath_i (
    .clk        (clk),
    .rst        (rst),
    .dpStb      (dpStb),
    .memData    (memData),
    .irLoad     (irLoad),
    .gprAdrLoad (gprAdrLoad),
    .instrBytes (instrBytes),
    .gprAdr     (gprAdr),
    .errOpcode  (errOpcode),
    .errMode    (errMode),
    .byteCount  (byteCount)
  );

  assign phase = phaseEnum;

endmodule

// File: rtl/ifetch_seq_chk.sv
`timescale 1ns/1ps
module ifetch_seq_chk #(
  parameter int MAX_BYTES = 4,
  parameter int GPR_W     = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 startReq,
  input logic                 memDone,
  input logic                 marLoad,
  input logic                 memRd,
  input logic [MAX_BYTES-1:0] irLoad,
  input logic [GPR_W-1:0]     gprAdr,
  input logic [GPR_W-1:0]     ir1Gpr,
  input logic                 errOpcode,
  input logic                 errMode,
  input logic [2:0]           phase
);

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (phase == 3'd0 && irLoad == '0 && !marLoad && !memRd)); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd0 && !startReq) |=> phase == 3'd0); // R2

  AST_WAIT_AFTER_MAR: assert property (@(posedge clk) disable iff (rst)
    marLoad |=> (!memRd && !marLoad)); // R3

  AST_LOAD_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    (memRd && memDone) |=> $countones(irLoad) == 1); // R4

  AST_IRLOAD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irLoad)); // R4

  AST_GPR_FROM_IR1: assert property (@(posedge clk) disable iff (rst)
    irLoad[1] |=> gprAdr == ir1Gpr); // R7

  AST_ERROP_TO_INTR: assert property (@(posedge clk) disable iff (rst)
    $rose(errOpcode) |-> phase == 3'd4); // R5

  AST_ERRMODE_TO_INTR: assert property (@(posedge clk) disable iff (rst)
    $rose(errMode) |-> phase == 3'd4); // R8

  AST_ERROP_STICKY: assert property (@(posedge clk) disable iff (rst)
    errOpcode |=> errOpcode); // R11

  AST_ERRMODE_STICKY: assert property (@(posedge clk) disable iff (rst)
    errMode |=> errMode); // R11

  AST_OPER_THEN_EXEC: assert property (@(posedge clk) disable iff (rst)
    phase == 3'd2 |=> phase == 3'd3); // R12

  AST_INTR_THEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    phase == 3'd4 |=> phase == 3'd0); // R12

endmodule

bind ifetch_seq ifetch_seq_chk #(
  .MAX_BYTES (MAX_BYTES),
  .GPR_W     (GPR_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .startReq  (startReq),
  .memDone   (memDone),
  .marLoad   (marLoad),
  .memRd     (memRd),
  .irLoad    (irLoad),
  .gprAdr    (gprAdr),
  .ir1Gpr    (instrBytes[BYTE_W +: GPR_W]),
  .errOpcode (errOpcode),
  .errMode   (errMode),
  .phase     (phase)
);

// File: tb/ifetch_seq_tb_top.sv
`timescale 1ns/1ps
module ifetch_seq_tb_top;

  localparam int BYTE_W    = 8;
  localparam int MAX_BYTES = 4;
  localparam int GPR_W     = 3;
  localparam int CNT_W     = $clog2(MAX_BYTES + 1);
  localparam int NVEC      = 11;

  // flags bit order: 0 illOp, 1 oneByte, 2 illMode, 3 branch, 4 regDirArith, 5 jump, 6 arith
  // path: 0 execute only, 1 operand then execute, 2 interrupt only (error)
  typedef struct packed {
    logic [6:0] flags;
    logic [2:0] busy;
    logic [2:0] lat;
    logic [2:0] nBytes;
    logic [1:0] path;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{7'b0000010, 3'd0, 3'd0, 3'd1, 2'd0},
    '{7'b0000000, 3'd2, 3'd1, 3'd4, 2'd1},
    '{7'b0001000, 3'd0, 3'd2, 3'd2, 2'd0},
    '{7'b0010000, 3'd1, 3'd0, 3'd2, 2'd1},
    '{7'b0100000, 3'd0, 3'd0, 3'd3, 2'd0},
    '{7'b1000000, 3'd3, 3'd3, 3'd3, 2'd1},
    '{7'b1100000, 3'd1, 3'd1, 3'd3, 2'd0},
    '{7'b0011000, 3'd0, 3'd1, 3'd2, 2'd0},
    '{7'b1111110, 3'd2, 3'd0, 3'd1, 2'd0},
    '{7'b0000011, 3'd0, 3'd0, 3'd1, 2'd2},
    '{7'b0001100, 3'd1, 3'd2, 3'd2, 2'd2}
  };

  logic clk = 1'b0;
  logic rst;
  logic startReq;
  logic busBusy;
  logic memDone;
  logic [BYTE_W-1:0] memData;
  logic [6:0] flagVec;
  logic marLoad, pcIncr, memRd, gprAdrLoad, errOpcode, errMode;
  logic [MAX_BYTES-1:0] irLoad;
  logic [BYTE_W*MAX_BYTES-1:0] instrBytes;
  logic [GPR_W-1:0] gprAdr;
  logic [2:0] phase;
  logic [CNT_W-1:0] byteCount;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  ifetch_seq #(.BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES), .GPR_W(GPR_W)) dut_i (
    .clk(clk), .rst(rst), .startReq(startReq), .busBusy(busBusy),
    .memDone(memDone), .memData(memData),
    .decIllegalOp(flagVec[0]), .decOneByte(flagVec[1]), .decIllegalMode(flagVec[2]),
    .decBranch(flagVec[3]), .decRegDirArith(flagVec[4]), .decJump(flagVec[5]),
    .decArith(flagVec[6]),
    .marLoad(marLoad), .pcIncr(pcIncr), .memRd(memRd), .irLoad(irLoad),
    .gprAdrLoad(gprAdrLoad), .instrBytes(instrBytes), .gprAdr(gprAdr),
    .errOpcode(errOpcode), .errMode(errMode), .phase(phase), .byteCount(byteCount)
  );

  function automatic logic [BYTE_W-1:0] memByte(input int a);
    return BYTE_W'(a * 37 + 11);
  endfunction

  // Bench-side memory and bus model, updated 1 ns after each rising edge
  int pcModel = 0;
  int marModel = 0;
  int busLeft = 0;
  int rdWait = 0;
  int busyCfg = 0;
  int latCfg = 0;

  initial begin
    busBusy = 1'b0;
    memDone = 1'b0;
    memData = '0;
    forever begin
      @(posedge clk);
      #1;
      if (marLoad) begin
        marModel = pcModel;
        pcModel  = pcModel + 1;
        busLeft  = busyCfg;
        busBusy  = (busyCfg != 0);
      end else if (busLeft != 0) begin
        busLeft = busLeft - 1;
        busBusy = (busLeft != 0);
      end
      if (memRd) begin
        if (rdWait == latCfg) begin
          memDone = 1'b1;
          memData = memByte(marModel);
        end else begin
          memDone = 1'b0;
        end
        rdWait = rdWait + 1;
      end else begin
        memDone = 1'b0;
        rdWait  = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint actual, input longint expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
    end
  endtask

  function automatic string pathTag(input int i);
    case (i)
      0, 8:    return "R6";
      2, 3:    return "R9";
      6, 7:    return "R13";
      9:       return "R5";
      10:      return "R8";
      default: return "R10";
    endcase
  endfunction

  bit expErrOp = 0;
  bit expErrMode = 0;

  task automatic runInstr(input vec_t v, input string tag);
    int startPc;
    int cyc = 0;
    int hsBad = 0;
    bit sawExec = 0;
    bit sawOper = 0;
    bit prevRd = 0;
    bit prevBusy = 0;
    int pathGot;
    @(negedge clk);
    flagVec  = v.flags;
    busyCfg  = int'(v.busy);
    latCfg   = int'(v.lat);
    startPc  = pcModel;
    startReq = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      if (marLoad !== pcIncr) hsBad++;
      if (memRd && !prevRd && prevBusy) hsBad++;
      if (prevRd && !memRd && $countones(irLoad) != 1) hsBad++;
      if (phase == 3'd2) sawOper = 1;
      if (phase == 3'd3) sawExec = 1;
      prevRd   = memRd;
      prevBusy = busBusy;
      if (phase == 3'd4 || cyc > 300) break;
    end
    startReq = 1'b0;
    check(cyc <= 300, tag, "reached interrupt phase", cyc, 300);
    check(hsBad == 0, "R3", "handshake violations", hsBad, 0);
    check(byteCount == CNT_W'(v.nBytes), tag, "bytes fetched", byteCount, v.nBytes);
    pathGot = sawOper ? 1 : (sawExec ? 0 : 2);
    if (sawOper && !sawExec) pathGot = 3;
    check(pathGot == int'(v.path), tag, "exit path", pathGot, v.path);
    for (int k = 0; k < int'(v.nBytes); k++) begin
      check(instrBytes[k*BYTE_W +: BYTE_W] == memByte(startPc + k), "R4", "IR byte",
            instrBytes[k*BYTE_W +: BYTE_W], memByte(startPc + k));
    end
    check(pcModel == startPc + int'(v.nBytes), "R3", "PC increments", pcModel - startPc, v.nBytes);
    if (v.nBytes >= 3'd2) begin
      logic [BYTE_W-1:0] b1 = memByte(startPc + 1);
      check(gprAdr == b1[GPR_W-1:0], "R7", "register address", gprAdr, b1[GPR_W-1:0]);
    end
    if (v.path == 2'd2 && v.nBytes == 3'd1) expErrOp = 1;
    if (v.path == 2'd2 && v.nBytes == 3'd2) expErrMode = 1;
    check(errOpcode == expErrOp, "R11", "opcode error bit", errOpcode, expErrOp);
    check(errMode == expErrMode, "R11", "mode error bit", errMode, expErrMode);
    @(negedge clk);
    check(phase == 3'd0, "R12", "interrupt returns to idle", phase, 0);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int seenMar;
    vec_t clean;
    rst = 1'b1;
    startReq = 1'b0;
    flagVec = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(phase == 3'd0, "R1", "phase after reset", phase, 0);
    check(irLoad == '0 && !marLoad && !pcIncr && !memRd, "R1", "strobes after reset",
          {irLoad, marLoad, pcIncr, memRd}, 0);
    check(!errOpcode && !errMode && byteCount == '0, "R1", "errors and count after reset",
          {errOpcode, errMode, byteCount}, 0);
    rst = 1'b0;

    // R2: idle without start
    seenMar = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (marLoad || phase != 3'd0) seenMar++;
    end
    check(seenMar == 0, "R2", "activity while start low", seenMar, 0);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      runInstr(VECS[i], pathTag(i));
    end

    // R11: clean one-byte instruction leaves both sticky errors set
    clean = '{7'b0000010, 3'd0, 3'd0, 3'd1, 2'd0};
    runInstr(clean, "R6");
    check(errOpcode && errMode, "R11", "errors persist", {errOpcode, errMode}, 2'b11);

    // R1: reset in the middle of a pending read
    @(negedge clk);
    flagVec  = '0;
    latCfg   = 7;
    busyCfg  = 0;
    startReq = 1'b1;
    for (int i = 0; i < 20 && !memRd; i++) @(negedge clk);
    startReq = 1'b0;
    check(memRd == 1'b1, "R3", "read pending before reset", memRd, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(phase == 3'd0 && irLoad == '0 && !memRd, "R1", "mid-read reset",
          {phase, irLoad, memRd}, 0);
    check(!errOpcode && !errMode, "R1", "errors cleared by reset", {errOpcode, errMode}, 0);
    expErrOp = 0;
    expErrMode = 0;
    @(negedge clk);
    check(phase == 3'd0, "R2", "stays idle after reset", phase, 0);

    // Recovery after reset: full four-byte fetch
    runInstr('{7'b0000000, 3'd1, 3'd2, 3'd4, 2'd1}, "R10");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule